// File: doc/BRIEF.md
# Prescaled Periodic Tick Timer

This block is a down-counting tick timer meant to sit beside a processor core. A programmable prescaler divides the core clock by (scale + 1). Each prescaler tick lowers a 32-bit count by one. When the count steps from one to zero, the block latches an expiry flag, and that flag drives a level interrupt request. Software then clears the flag by writing a one to it. When reload is selected, the count is refilled from a period register at the moment it expires. This gives a steady interrupt rate of clk / ((scale + 1) * period). Without reload, the timer makes a single timeout and then rests at zero.

Software reaches four registers through a plain strobe interface: a write strobe, an address and write data, with combinational read data. Register 0 is control, 1 is the count, 2 is the period and 3 is the scale. Two control bits, power and enable, must both be set before the timer counts. A debug halt input freezes both the prescaler and the count, so that time spent stopped in a debugger does not reach the application.

A four-state machine governs the counting:
- OFF: power or enable is clear.
- RUN: counting.
- HALT: frozen by the debug halt.
- IDLE: count is zero and no reload is pending.

Its transitions are:
- POWER_UP: OFF to RUN.
- POWER_DOWN: any state to OFF.
- FREEZE: RUN or IDLE to HALT.
- THAW: HALT back to RUN or IDLE.
- EXPIRE: RUN to IDLE.
- REARM: IDLE to RUN after a count write.
- OFF may also go straight to HALT or IDLE.

The state register sees a change of its inputs one clock later. That one-cycle lag is included in every timing figure below.

Top module: `tick_timer_top`

## Requirements
- R1: After reset, every register reads zero and `irq` is low. Control bits are power = bit 0, enable = bit 1, reload = bit 2 and flag = bit 3.
- R2: With only one of power or enable set, the count does not change.
- R3: After a control write sets power and enable with a nonzero count C and scale S, `irq` first rises 1 + C*(S+1) cycles after the write edge.
- R4: An expiry sets the flag (control bit 3), and `irq` follows the flag.
- R5: Writing control with bit 3 = 1 clears the flag. Writing bit 3 = 0 leaves the flag unchanged.
- R6: An expiry in the same cycle as a clear write leaves the flag set.
- R7: With reload set, the count reads back as the period right after an expiry. Successive expiries are then period*(S+1) cycles apart.
- R8: Without reload, after an expiry the count stays at zero and no new expiry occurs. Writing a nonzero count C restarts counting, and `irq` rises 1 + C*(S+1) cycles after that write edge.
- R9: Holding `emu_halt` high for H cycles while counting delays the expiry by exactly H cycles, and the count holds still meanwhile.
- R10: Writing the scale register restarts the prescaler. With S = 7 and C = 3, a scale write 4 cycles after the enable edge moves the expiry to 24 cycles after that write edge.
- R11: Register readback works as follows:
  - Period (address 2) returns what was written.
  - Scale (address 3) returns only the low 8 bits.
  - Control (address 0) returns only bits 3..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 control, 1 count, 2 period, 3 scale |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| emu_halt | input | 1 | Debug halt; freezes prescaler and count |
| irq | output | 1 | Level interrupt request (equals the expiry flag) |

## Verification
The main timing is tried with random pairs of count and scale, with and without reload. This separates an off-by-one in the prescaler reload from one in the count-to-zero detection, and a reload taken from the period from one taken from the old count. Directed patterns then land a clear write exactly on the expiry edge, and hold the halt input for a fixed span in mid-count. They also rewrite the scale four cycles into a run, which shows whether the prescaler truly restarts or simply keeps going. Single-bit power or enable settings, and zero versus one written to the flag, separate the gating and write-one-to-clear behaviour from plain register writes.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2,
        ST_IDLE = 2'd3
    } tick_state_e;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_COUNT  = 2'd1;
    localparam logic [1:0] ADDR_PERIOD = 2'd2;
    localparam logic [1:0] ADDR_SCALE  = 2'd3;

    localparam int BIT_POWER  = 0;
    localparam int BIT_ENABLE = 1;
    localparam int BIT_RELOAD = 2;
    localparam int BIT_FLAG   = 3;
    localparam int CTRL_BITS  = 4;

endpackage

// File: rtl/tick_regs.sv
module tick_regs
    import tick_timer_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int SCALE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         addr_i,
    input  logic               wr_i,
    input  logic [CNT_W-1:0]   wdata_i,
    output logic [CNT_W-1:0]   rdata_o,
    input  logic               expire_i,
    input  logic [CNT_W-1:0]   count_i,
    output logic               power_o,
    output logic               enable_o,
    output logic               reload_o,
    output logic               flag_o,
    output logic [CNT_W-1:0]   period_o,
    output logic [SCALE_W-1:0] scale_o,
    output logic               scale_wr_o,
    output logic               count_wr_o
);

    localparam int CTRL_PAD  = CNT_W - CTRL_BITS;
    localparam int SCALE_PAD = CNT_W - SCALE_W;

    logic ctrl_wr;
    logic period_wr;
    logic clear_req;

    assign ctrl_wr    = wr_i && (addr_i == ADDR_CTRL);
    assign count_wr_o = wr_i && (addr_i == ADDR_COUNT);
    assign period_wr  = wr_i && (addr_i == ADDR_PERIOD);
    assign scale_wr_o = wr_i && (addr_i == ADDR_SCALE);
    assign clear_req  = ctrl_wr && wdata_i[BIT_FLAG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            power_o  <= 1'b0;
            enable_o <= 1'b0;
            reload_o <= 1'b0;
        end else if (ctrl_wr) begin
            power_o  <= wdata_i[BIT_POWER];
            enable_o <= wdata_i[BIT_ENABLE];
            reload_o <= wdata_i[BIT_RELOAD];
        end
    end

    // Expiry outranks a simultaneous clear so no event is lost.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (expire_i) begin
            flag_o <= 1'b1;
        end else if (clear_req) begin
            flag_o <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_o <= '0;
        end else if (period_wr) begin
            period_o <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scale_o <= '0;
        end else if (scale_wr_o) begin
            scale_o <= wdata_i[SCALE_W-1:0];
        end
    end

    always_comb begin
        unique case (addr_i)
            ADDR_CTRL:   rdata_o = {{CTRL_PAD{1'b0}}, flag_o, reload_o, enable_o, power_o};
            ADDR_COUNT:  rdata_o = count_i;
            ADDR_PERIOD: rdata_o = period_o;
            ADDR_SCALE:  rdata_o = {{SCALE_PAD{1'b0}}, scale_o};
            default:     rdata_o = '0;
        endcase
    end

    assert_flag_on_expiry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> flag_o);

    assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_req && !expire_i) |=> !flag_o);

    assert_expiry_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_req && expire_i) |=> flag_o);

    assert_zero_write_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wdata_i[BIT_FLAG] && flag_o) |=> flag_o);

endmodule

// File: rtl/tick_fsm.sv
module tick_fsm
    import tick_timer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        power_i,
    input  logic        enable_i,
    input  logic        halt_i,
    input  logic        count_zero_i,
    output tick_state_e state_o,
    output logic        run_o,
    output logic        restart_o
);

    tick_state_e state_q;
    tick_state_e state_d;
    logic        active;

    assign active = power_i && enable_i;

    // Next-state selection; transition names follow the brief.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (active) begin
                    if (halt_i)            state_d = ST_HALT;  // OFF -> HALT
                    else if (count_zero_i) state_d = ST_IDLE;  // OFF -> IDLE
                    else                   state_d = ST_RUN;   // POWER_UP
                end
            end
            ST_RUN: begin
                if (!active)           state_d = ST_OFF;       // POWER_DOWN
                else if (halt_i)       state_d = ST_HALT;      // FREEZE
                else if (count_zero_i) state_d = ST_IDLE;      // EXPIRE
            end
            ST_HALT: begin
                if (!active)           state_d = ST_OFF;       // POWER_DOWN
                else if (!halt_i)      state_d = count_zero_i ? ST_IDLE : ST_RUN; // THAW
            end
            ST_IDLE: begin
                if (!active)           state_d = ST_OFF;       // POWER_DOWN
                else if (halt_i)       state_d = ST_HALT;      // FREEZE
                else if (!count_zero_i) state_d = ST_RUN;      // REARM
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the registered state.
    always_comb begin
        run_o     = 1'b0;
        restart_o = 1'b0;
        unique case (state_q)
            ST_OFF:  restart_o = 1'b1;
            ST_RUN:  run_o     = 1'b1;
            ST_HALT: ;
            ST_IDLE: restart_o = 1'b1;
            default: restart_o = 1'b1;
        endcase
    end

    assign state_o = state_q;

    assert_gate_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(power_i && enable_i) |=> (state_q == ST_OFF));

    assert_run_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({run_o, restart_o}));

endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int SCALE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               restart_i,
    input  logic               scale_wr_i,
    input  logic [SCALE_W-1:0] scale_new_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic               tick_o
);

    logic [SCALE_W-1:0] pre_q;

    assign tick_o = run_i && (pre_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (scale_wr_i) begin
            pre_q <= scale_new_i;
        end else if (restart_i) begin
            pre_q <= scale_i;
        end else if (run_i) begin
            pre_q <= tick_o ? scale_i : pre_q - 1'b1;
        end
    end

    assert_pre_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= scale_i);

    assert_pre_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !restart_i && !scale_wr_i) |=> $stable(pre_q));

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             count_wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic at_last;

    assign at_last  = (count_o == ONE);
    assign expire_o = tick_i && at_last && !count_wr_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (count_wr_i) begin
            count_o <= wdata_i;
        end else if (tick_i && (count_o != '0)) begin
            if (at_last) begin
                count_o <= reload_i ? period_i : '0;
            end else begin
                count_o <= count_o - ONE;
            end
        end
    end

    assert_reload_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && reload_i) |=> (count_o == $past(period_i)));

    assert_single_shot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !reload_i) |=> (count_o == '0));

endmodule

// File: rtl/tick_timer_top.sv
module tick_timer_top
    import tick_timer_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int SCALE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic             emu_halt,
    output logic             irq
);

    logic               power;
    logic               enable;
    logic               reload;
    logic               flag;
    logic [CNT_W-1:0]   period;
    logic [SCALE_W-1:0] scale;
    logic               scale_wr;
    logic               count_wr;
    logic [CNT_W-1:0]   count;
    logic               expire;
    logic               tick;
    logic               run;
    logic               restart;
    tick_state_e        state;

    tick_regs #(.CNT_W(CNT_W), .SCALE_W(SCALE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (reg_addr),
        .wr_i       (reg_wr),
        .wdata_i    (reg_wdata),
        .rdata_o    (reg_rdata),
        .expire_i   (expire),
        .count_i    (count),
        .power_o    (power),
        .enable_o   (enable),
        .reload_o   (reload),
        .flag_o     (flag),
        .period_o   (period),
        .scale_o    (scale),
        .scale_wr_o (scale_wr),
        .count_wr_o (count_wr)
    );

    tick_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .power_i      (power),
        .enable_i     (enable),
        .halt_i       (emu_halt),
        .count_zero_i (count == '0),
        .state_o      (state),
        .run_o        (run),
        .restart_o    (restart)
    );

    tick_prescaler #(.SCALE_W(SCALE_W)) u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .restart_i   (restart),
        .scale_wr_i  (scale_wr),
        .scale_new_i (reg_wdata[SCALE_W-1:0]),
        .scale_i     (scale),
        .tick_o      (tick)
    );

    tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .count_wr_i (count_wr),
        .wdata_i    (reg_wdata),
        .reload_i   (reload),
        .period_i   (period),
        .count_o    (count),
        .expire_o   (expire)
    );

    assign irq = flag;

    assert_off_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && !count_wr) |=> $stable(count));

    assert_halt_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !count_wr) |=> $stable(count));

    assert_idle_rests_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && count == '0 && !count_wr) |=> (count == '0));

    assert_irq_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(expire));

endmodule

// File: tb/test_tick_timer_top.sv
`timescale 1ns/1ps
module test_tick_timer_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        emu_halt = 1'b0;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;

    localparam logic [1:0] A_CTRL = 2'd0, A_COUNT = 2'd1, A_PERIOD = 2'd2, A_SCALE = 2'd3;

    always #10 clk = ~clk;

    tick_timer_top i_tick_timer_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .emu_halt  (emu_halt),
        .irq       (irq)
    );

    function automatic int first_latency(int c, int s);
        return 1 + c * (s + 1);
    endfunction

    function automatic int reload_gap(int p, int s);
        return p * (s + 1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Caller sits just after a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq && n < 20000);
    endtask

    task automatic setup(input int c, input int s, input int p);
        wr(A_CTRL, 32'h8);
        wr(A_SCALE, 32'(s));
        wr(A_COUNT, 32'(c));
        wr(A_PERIOD, 32'(p));
    endtask

    task automatic start(input bit rl);
        wr(A_CTRL, rl ? 32'h7 : 32'h3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] v2;
        int n;
        int j;
        void'($urandom(32'h5EED));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(A_CTRL, v);   chk("R1 ctrl", v, 0);
        rd(A_COUNT, v);  chk("R1 count", v, 0);
        rd(A_PERIOD, v); chk("R1 period", v, 0);
        rd(A_SCALE, v);  chk("R1 scale", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R11 readback
        wr(A_PERIOD, 32'hDEADBEEF);
        rd(A_PERIOD, v); chk("R11 period", v, 32'hDEADBEEF);
        wr(A_SCALE, 32'h1A5);
        rd(A_SCALE, v);  chk("R11 scale", v, 32'hA5);
        wr(A_COUNT, 0);
        wr(A_CTRL, 32'hFFFFFFF7);
        rd(A_CTRL, v);   chk("R11 ctrl", v, 32'h7);

        // R2 gating
        setup(5, 0, 0);
        wr(A_CTRL, 32'h1);
        repeat (20) @(negedge clk);
        rd(A_COUNT, v); chk("R2 power only", v, 5);
        wr(A_CTRL, 32'h2);
        repeat (20) @(negedge clk);
        rd(A_COUNT, v); chk("R2 enable only", v, 5);
        chk("R2 irq", {31'd0, irq}, 0);

        // R3 directed and R4 flag
        setup(4, 2, 0);
        start(0);
        wait_irq(n);
        chk("R3 latency", 32'(n), 32'(first_latency(4, 2)));
        rd(A_CTRL, v); chk("R4 flag bit", v[3], 1);

        // R6 clear on the expiry edge
        setup(3, 2, 0);
        start(0);
        repeat (3 * 3) @(negedge clk);
        wr(A_CTRL, 32'hB);
        chk("R6 expiry beats clear", {31'd0, irq}, 1);

        // R5 write zero then one
        wr(A_CTRL, 32'h3);
        chk("R5 zero write keeps", {31'd0, irq}, 1);
        wr(A_CTRL, 32'hB);
        chk("R5 one write clears", {31'd0, irq}, 0);

        // R8 single shot rests at zero then rearms
        rd(A_COUNT, v); chk("R8 count zero", v, 0);
        repeat (20) @(negedge clk);
        rd(A_COUNT, v); chk("R8 still zero", v, 0);
        chk("R8 no new expiry", {31'd0, irq}, 0);
        wr(A_COUNT, 2);
        wait_irq(n);
        chk("R8 rearm latency", 32'(n), 32'(first_latency(2, 2)));

        // R7 reload
        setup(4, 1, 4);
        start(1);
        wait_irq(n);
        chk("R7 first", 32'(n), 32'(first_latency(4, 1)));
        rd(A_COUNT, v); chk("R7 reloaded count", v, 4);
        wr(A_CTRL, 32'hF);
        wait_irq(n);
        chk("R7 gap", 32'(n + 1), 32'(reload_gap(4, 1)));

        // R10 scale write restarts prescaler
        setup(3, 7, 0);
        start(0);
        repeat (3) @(negedge clk);
        wr(A_SCALE, 7);
        wait_irq(n);
        chk("R10 restart", 32'(n), 32'd24);

        // R9 halt for 6 cycles
        setup(10, 1, 0);
        start(0);
        reg_addr = A_COUNT;
        v = 0; v2 = 1;
        j = 0;
        do begin
            @(negedge clk);
            j++;
            emu_halt = (j >= 4 && j < 10);
            if (j == 6) begin #1; v = reg_rdata; end
            if (j == 8) begin #1; v2 = reg_rdata; end
        end while (!irq && j < 20000);
        emu_halt = 1'b0;
        chk("R9 count frozen", v2, v);
        chk("R9 delay", 32'(j), 32'(first_latency(10, 1) + 6));

        // Random trials for R3 and R7
        for (int t = 0; t < 12; t++) begin
            int c;
            int s;
            bit rl;
            c  = int'($urandom_range(1, 12));
            s  = int'($urandom_range(0, 5));
            rl = 1'($urandom_range(0, 1));
            setup(c, s, c);
            start(rl);
            wait_irq(n);
            chk("R3 random latency", 32'(n), 32'(first_latency(c, s)));
            if (rl) begin
                wr(A_CTRL, 32'hF);
                wait_irq(n);
                chk("R7 random gap", 32'(n + 1), 32'(reload_gap(c, s)));
            end else begin
                rd(A_COUNT, v);
                chk("R8 random rest", v, 0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule